// File: doc/BRIEF.md
# Per-Stream Channel Tag Rewriter

This block sits on a wide receive stream (512-bit data, four 16-byte segments per beat). Packets from many streams and channels share it. A beat can carry the tail of one packet and the head of the next. The block keeps one channel-ID register per stream. That register is loaded from the live tag when a packet starts and read back on every later beat of the packet. Every outgoing beat therefore carries a tag that names the right stream and channel: for the packet that is starting or running, and for the packet that ends when a second one starts in the same beat.

Start and end positions come in as one bit per segment, with bit i standing for bytes 16i to 16i+15. A mode input chooses between single-packet operation and multi-packet operation. In single-packet mode only the lower tag half is meaningful. In multi-packet mode the upper half describes the packet that ends in a beat that also holds a new start. Data, keep and last pass through one register stage unchanged. A sticky flag records beats that break the framing rules.

Top module: `chan_tag_buffer`

Tag layout: [31:26] stream of the ending packet, [25:16] its channel, [15:10] stream of the starting or only packet, [9:0] its channel.

## Requirements
- R1: After reset, m_tvalid and err_flag are 0 and every stored channel is 0. A non-start beat on a stream that has not yet started a packet reports channel 0.
- R2: An accepted beat appears on the outputs exactly one cycle later, with m_tdata, m_tkeep and m_tlast equal to the inputs.
- R3: s_tready is 1 whenever m_tready is 1 or m_tvalid is 0. While m_tvalid is 1 and m_tready is 0, the outputs hold their values.
- R4: On a beat with exactly one start bit, m_tid[15:0] equals the input s_tid[15:0]. The register of stream s_tid[15:10] is then loaded with s_tid[9:0].
- R5: On a beat with no start bit, m_tid[15:0] is {s_tid[15:10], the stored channel of that stream}.
- R6: In multi-packet mode, a two-packet beat (one end bit in segment k and one start bit in a segment above k) outputs m_tid[31:16] = {s_tid[31:26], the channel stored for that stream before the beat}. The input s_tid[25:16] is ignored. The lower half is the live input, and the register then holds the new channel.
- R7: A beat that is not a two-packet beat outputs m_tid[31:16] = 0.
- R8: In single-packet mode the output upper half is always 0, whatever s_tid[31:16] holds. A start that follows an end in the same beat raises err_flag.
- R9: err_flag is set by a beat with more than one start bit, more than one end bit, a two-packet beat whose two stream fields differ, or a stream field not below NUM_STREAMS. It stays set until reset.
- R10: A start bit in the same segment as the end bit, or in a lower segment, marks one complete short packet. Such a beat is not a two-packet beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| multi_mode | input | 1 | 1 = multi-packet mode, 0 = single-packet mode |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tdata | input | 512 | Input data |
| s_tkeep | input | 64 | Input byte enables |
| s_tlast | input | 1 | Input last flag |
| s_tid | input | 32 | Input tag |
| s_sop_seg | input | 4 | Start-of-packet bit per segment |
| s_eop_seg | input | 4 | End-of-packet bit per segment |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 512 | Output data |
| m_tkeep | output | 64 | Output byte enables |
| m_tlast | output | 1 | Output last flag |
| m_tid | output | 32 | Rewritten tag |
| err_flag | output | 1 | Sticky framing violation flag |

## Verification
Some rules are checked on every cycle. These are the one-cycle landing of beats with unchanged data, keep and last, the hold under backpressure, the zero upper tag half in single-packet mode and on beats without both a start and an end, the live lower half on start beats, and the stickiness of the error flag and its rise on doubled markers. Other results depend on the register contents, so only the directed scenarios can show them. These are the channel recalled mid-packet, the value read before overwrite on a two-packet beat, the zero reported for a never-started stream, short packets that start and end in one beat, and errors from mismatched or out-of-range stream fields.

// File: rtl/chan_tag_buffer.sv
module chan_tag_buffer #(
  parameter int NUM_STREAMS = 4,
  parameter int DATA_W      = 512,
  parameter int SEGS        = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                multi_mode,
  input  logic                s_tvalid,
  output logic                s_tready,
  input  logic [DATA_W-1:0]   s_tdata,
  input  logic [DATA_W/8-1:0] s_tkeep,
  input  logic                s_tlast,
  input  logic [31:0]         s_tid,
  input  logic [SEGS-1:0]     s_sop_seg,
  input  logic [SEGS-1:0]     s_eop_seg,
  output logic                m_tvalid,
  input  logic                m_tready,
  output logic [DATA_W-1:0]   m_tdata,
  output logic [DATA_W/8-1:0] m_tkeep,
  output logic                m_tlast,
  output logic [31:0]         m_tid,
  output logic                err_flag
);
  localparam int SIDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;
  localparam int SEG_W  = (SEGS > 1) ? $clog2(SEGS) : 1;

  logic [9:0] chan_q [NUM_STREAMS];

  logic [5:0]       strm0, strm1, rd_strm;
  logic [SEG_W-1:0] sop_pos, eop_pos;
  logic             one_sop, one_eop, two_pkt, rd_ok, wr_ok, bad, acc;
  logic [9:0]       stored;
  logic [31:0]      tid_nx;
  wire              unused_c1 = ^s_tid[25:16];

  assign strm0    = s_tid[15:10];
  assign strm1    = s_tid[31:26];
  assign s_tready = m_tready | ~m_tvalid;
  assign acc      = s_tvalid & s_tready;
  assign one_sop  = $countones(s_sop_seg) == 1;
  assign one_eop  = $countones(s_eop_seg) == 1;

  always_comb begin
    sop_pos = '0;
    eop_pos = '0;
    for (int i = 0; i < SEGS; i++) begin
      if (s_sop_seg[i]) sop_pos = SEG_W'(i);
      if (s_eop_seg[i]) eop_pos = SEG_W'(i);
    end
  end

  assign two_pkt = one_sop & one_eop & (sop_pos > eop_pos);
  assign rd_strm = (two_pkt & multi_mode) ? strm1 : strm0;
  assign rd_ok   = 32'(rd_strm) < NUM_STREAMS;
  assign wr_ok   = 32'(strm0) < NUM_STREAMS;
  assign stored  = rd_ok ? chan_q[rd_strm[SIDX_W-1:0]] : 10'd0;

  always_comb begin
    tid_nx = '0;
    if (two_pkt && multi_mode) begin
      tid_nx[31:16] = {strm1, stored};
      tid_nx[15:0]  = s_tid[15:0];
    end else if (s_sop_seg != '0) begin
      tid_nx[15:0]  = s_tid[15:0];
    end else begin
      tid_nx[15:0]  = {strm0, stored};
    end
  end

  assign bad = ($countones(s_sop_seg) > 1) | ($countones(s_eop_seg) > 1) |
               (two_pkt & ~multi_mode) |
               (two_pkt & multi_mode & (strm1 != strm0)) |
               ~wr_ok | ~rd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_STREAMS; i++) chan_q[i] <= '0;
      err_flag <= 1'b0;
    end else if (acc) begin
      if (one_sop && wr_ok) chan_q[strm0[SIDX_W-1:0]] <= s_tid[9:0];
      if (bad) err_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tkeep  <= '0;
      m_tlast  <= 1'b0;
      m_tid    <= '0;
    end else if (s_tready) begin
      m_tvalid <= s_tvalid;
      if (s_tvalid) begin
        m_tdata <= s_tdata;
        m_tkeep <= s_tkeep;
        m_tlast <= s_tlast;
        m_tid   <= tid_nx;
      end
    end
  end
endmodule

// File: rtl/chan_tag_buffer_chk.sv
module chan_tag_buffer_chk #(
  parameter int DATA_W = 512,
  parameter int SEGS   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                multi_mode,
  input logic                s_tvalid,
  input logic                s_tready,
  input logic [DATA_W-1:0]   s_tdata,
  input logic [DATA_W/8-1:0] s_tkeep,
  input logic                s_tlast,
  input logic [31:0]         s_tid,
  input logic [SEGS-1:0]     s_sop_seg,
  input logic [SEGS-1:0]     s_eop_seg,
  input logic                m_tvalid,
  input logic                m_tready,
  input logic [DATA_W-1:0]   m_tdata,
  input logic [DATA_W/8-1:0] m_tkeep,
  input logic                m_tlast,
  input logic [31:0]         m_tid,
  input logic                err_flag
);
  wire acc = s_tvalid & s_tready;

  p_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> m_tvalid && m_tlast == $past(s_tlast) && m_tkeep == $past(s_tkeep)
            && m_tdata == $past(s_tdata));
  p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_tready |-> s_tready);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tid) && $stable(m_tdata) && $stable(m_tlast));
  p_sop_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && $countones(s_sop_seg) == 1 |=> m_tid[15:0] == $past(s_tid[15:0]));
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (s_sop_seg == '0 || s_eop_seg == '0) |=> m_tid[31:16] == 16'd0);
  p_single_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !multi_mode |=> m_tid[31:16] == 16'd0);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  p_err_double_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ($countones(s_sop_seg) > 1 || $countones(s_eop_seg) > 1) |=> err_flag);
endmodule

bind chan_tag_buffer chan_tag_buffer_chk #(.DATA_W(DATA_W), .SEGS(SEGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .multi_mode(multi_mode),
  .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
  .s_tlast(s_tlast), .s_tid(s_tid), .s_sop_seg(s_sop_seg), .s_eop_seg(s_eop_seg),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
  .m_tlast(m_tlast), .m_tid(m_tid), .err_flag(err_flag)
);

// File: tb/chan_tag_buffer_bench.sv
module chan_tag_buffer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         multi_mode = 1'b1;
  logic         s_tvalid = 1'b0;
  logic         s_tready;
  logic [511:0] s_tdata = '0;
  logic [63:0]  s_tkeep = '0;
  logic         s_tlast = 1'b0;
  logic [31:0]  s_tid = '0;
  logic [3:0]   s_sop_seg = '0;
  logic [3:0]   s_eop_seg = '0;
  logic         m_tvalid;
  logic         m_tready = 1'b1;
  logic [511:0] m_tdata;
  logic [63:0]  m_tkeep;
  logic         m_tlast;
  logic [31:0]  m_tid;
  logic         err_flag;

  int tests = 0, fails = 0, seq = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_tag_buffer u_chan_tag_buffer (.*);

  function automatic logic [31:0] tag(input int s1, input int c1, input int s0, input int c0);
    return {6'(s1), 10'(c1), 6'(s0), 10'(c0)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_tvalid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive at a negedge, check at the following negedge
  task automatic beat(input logic [3:0] sop, input logic [3:0] eop, input logic [31:0] tid,
                      input logic last, input logic [31:0] exp_tid, input string req);
    logic [511:0] d;
    logic [63:0]  k;
    seq++;
    d = {16{32'hA5000000 ^ 32'(seq)}};
    k = {2{32'(seq) * 32'h9E3779B1}};
    s_tvalid = 1'b1; s_sop_seg = sop; s_eop_seg = eop; s_tid = tid;
    s_tdata = d; s_tkeep = k; s_tlast = last;
    @(negedge clk);
    s_tvalid = 1'b0;
    check({req, " tag"}, m_tid, exp_tid);
    check("R2 valid", 32'(m_tvalid), 32'd1);
    check("R2 data", m_tdata[31:0] ^ m_tdata[511:480], 32'd0);
    check("R2 data word", m_tdata[31:0], d[31:0]);
    check("R2 keep", m_tkeep[31:0], k[31:0]);
    check("R2 last", 32'(m_tlast), 32'(last));
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 valid after reset", 32'(m_tvalid), 32'd0);
    check("R1 err after reset", 32'(err_flag), 32'd0);
    beat(4'b0000, 4'b0000, tag(0, 0, 2, 0), 1'b0, tag(0, 0, 2, 0), "R1 R5 unstarted stream");
  endtask

  task automatic t_sop_and_recall();
    beat(4'b0001, 4'b0000, tag(0, 0, 0, 1), 1'b0, tag(0, 0, 0, 1), "R4 R7 start stream0 ch1");
    beat(4'b0000, 4'b0000, tag(0, 0, 0, 0), 1'b0, tag(0, 0, 0, 1), "R5 mid stream0");
  endtask

  task automatic t_two_packet();
    beat(4'b0010, 4'b0001, tag(0, 999, 0, 4), 1'b1, tag(0, 1, 0, 4), "R6 two-packet beat");
    beat(4'b0000, 4'b0000, tag(0, 0, 0, 0), 1'b0, tag(0, 0, 0, 4), "R6 register updated");
    beat(4'b0001, 4'b0000, tag(0, 0, 1, 6), 1'b0, tag(0, 0, 1, 6), "R4 start stream1 ch6");
    beat(4'b1000, 4'b0010, tag(1, 3, 1, 7), 1'b1, tag(1, 6, 1, 7), "R6 eop seg1 sop seg3");
    check("R6 no error", 32'(err_flag), 32'd0);
  endtask

  task automatic t_short_packet();
    beat(4'b0010, 4'b0100, tag(9, 9, 2, 11), 1'b1, tag(0, 0, 2, 11), "R10 sop below eop");
    beat(4'b0100, 4'b0100, tag(9, 9, 3, 12), 1'b1, tag(0, 0, 3, 12), "R10 sop equals eop");
    beat(4'b0000, 4'b0000, tag(0, 0, 2, 0), 1'b0, tag(0, 0, 2, 11), "R10 R4 stream2 stored");
    check("R10 no error", 32'(err_flag), 32'd0);
  endtask

  task automatic t_stall();
    beat(4'b0000, 4'b0000, tag(0, 0, 3, 0), 1'b0, tag(0, 0, 3, 12), "R3 first beat");
    m_tready = 1'b0;
    s_tvalid = 1'b1; s_sop_seg = 4'b0001; s_tid = tag(0, 0, 3, 40); s_tlast = 1'b1;
    #1;
    check("R3 ready low", 32'(s_tready), 32'd0);
    @(negedge clk);
    check("R3 held tag", m_tid, tag(0, 0, 3, 12));
    check("R3 held last", 32'(m_tlast), 32'd0);
    m_tready = 1'b1;
    #1;
    check("R3 ready high", 32'(s_tready), 32'd1);
    @(negedge clk);
    s_tvalid = 1'b0;
    check("R3 released tag", m_tid, tag(0, 0, 3, 40));
    check("R3 released last", 32'(m_tlast), 32'd1);
  endtask

  task automatic t_single_mode();
    multi_mode = 1'b0;
    beat(4'b0001, 4'b0000, tag(7, 777, 3, 5), 1'b0, tag(0, 0, 3, 5), "R8 upper ignored");
    beat(4'b0000, 4'b0001, tag(5, 55, 3, 0), 1'b1, tag(0, 0, 3, 5), "R8 single end");
    check("R8 no error", 32'(err_flag), 32'd0);
    beat(4'b0010, 4'b0001, tag(3, 0, 3, 8), 1'b1, tag(0, 0, 3, 8), "R8 two packets in single");
    check("R8 error raised", 32'(err_flag), 32'd1);
    multi_mode = 1'b1;
  endtask

  task automatic t_errors();
    do_reset();
    beat(4'b0101, 4'b0000, tag(0, 0, 1, 2), 1'b0, tag(0, 0, 1, 2), "R9 double start beat");
    check("R9 double start", 32'(err_flag), 32'd1);
    beat(4'b0000, 4'b0000, tag(0, 0, 1, 0), 1'b0, tag(0, 0, 1, 0), "R9 R4 no write on double");
    check("R9 sticky", 32'(err_flag), 32'd1);
    do_reset();
    beat(4'b0000, 4'b0011, tag(0, 0, 0, 0), 1'b1, tag(0, 0, 0, 0), "R9 double end beat");
    check("R9 double end", 32'(err_flag), 32'd1);
    do_reset();
    beat(4'b1000, 4'b0001, tag(1, 0, 0, 3), 1'b1, tag(1, 0, 0, 3), "R9 mixed streams beat");
    check("R9 mixed streams", 32'(err_flag), 32'd1);
    do_reset();
    beat(4'b0001, 4'b0000, tag(0, 0, 5, 9), 1'b0, tag(0, 0, 5, 9), "R9 range beat");
    check("R9 stream out of range", 32'(err_flag), 32'd1);
  endtask

  initial begin
    t_reset();
    t_sop_and_recall();
    t_two_packet();
    t_short_packet();
    t_stall();
    t_single_mode();
    t_errors();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule